// File: doc/BRIEF.md
# I2C SCL Timing Generator and Line Filter

This block is the bit-timing layer of an I2C controller. It produces the controller's SCL waveform from separate high-phase and low-phase cycle counts, all counted in system clock cycles. Inside each low phase it marks the one cycle in which the shifter above it may change SDA. That cycle lies a programmable hold count after SCL is pulled low, and a programmable setup count of low cycles always follows it before SCL is released. A byte sequencer drives `run_i` to request clock pulses and uses `sda_change_o` to time its SDA updates.

Both incoming bus lines pass through a two-stage synchronizer and a spike filter. A filtered line takes a new level only after the synchronized input has held that level for the programmed number of cycles. The high phase is timed from the filtered SCL, so a target that holds SCL low stretches the clock. For bus recovery, two force bits can pull SCL or SDA low. Each has its own write strobe, so writing one never disturbs the other. A 4-bit monitor word shows the filtered levels and both force bits.

Top module: `i2c_scl_timing`

## Requirements
- R1: While reset is asserted, SCL and SDA are released, `sda_change_o` is 0, both filtered lines read 1 and `mon_o` reads 4'b0011.
- R2: With `run_i` high in idle, SCL is driven low from the next cycle. Every generated low phase lasts max(Lc, Hd+Su+1) cycles, where Lc is the low count, Hd the hold count and Su the setup count.
- R3: `sda_change_o` is high for exactly one cycle in each low phase. That cycle is the one at index Hd, counting the first low cycle as index 0.
- R4: Between the change cycle and the release of SCL there are at least Su further low cycles. When the setup count dominates, there are exactly Su.
- R5: After release, the high count starts only once filtered SCL reads 1. Without stretching, SCL stays released for Hc+F+3 cycles, where Hc is the high count (0 acts as 1) and F is the filter length. The 3 cycles are two synchronizer stages and one decision cycle.
- R6: While the raw SCL input is held low by a target, the high count does not run. The released period grows by at least the stretch time.
- R7: Filtered SCL changes only after the synchronized raw SCL has held the new level for F consecutive cycles (F=0 acts as 1). Shorter pulses never appear on the output.
- R8: The SDA input is filtered by the same rule as SCL, with the same length.
- R9: While the SCL force bit is set, `scl_drive_low_o` is 1, whatever the generator state.
- R10: `mon_o` bit 0 is filtered SCL, bit 1 is filtered SDA, bit 2 is the SCL force bit and bit 3 is the SDA force bit. A write with only `ovr_scl_we_i` leaves bit 3 unchanged, and a write with only `ovr_sda_we_i` leaves bit 2 unchanged.
- R11: `sda_force_low_o` follows the SDA force bit, with a one-cycle delay from its write.
- R12: Dropping `run_i` during a low phase does not shorten that phase. The block then completes the high phase and stays idle with SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Request further SCL pulses |
| scl_high_cyc_i | input | CW | SCL high count in cycles |
| scl_low_cyc_i | input | CW | SCL low count in cycles |
| sda_setup_cyc_i | input | CW | Low cycles required after the SDA change cycle |
| sda_hold_cyc_i | input | CW | Low cycles before the SDA change cycle |
| filt_len_i | input | FW | Spike filter length in cycles |
| scl_raw_i | input | 1 | Raw SCL bus level |
| sda_raw_i | input | 1 | Raw SDA bus level |
| ovr_scl_we_i | input | 1 | Write strobe for the SCL force bit |
| ovr_scl_i | input | 1 | New SCL force bit value |
| ovr_sda_we_i | input | 1 | Write strobe for the SDA force bit |
| ovr_sda_i | input | 1 | New SDA force bit value |
| scl_drive_low_o | output | 1 | Open-drain SCL pull-down enable |
| sda_force_low_o | output | 1 | Open-drain SDA pull-down from the force bit |
| sda_change_o | output | 1 | Cycle in which SDA may change |
| scl_filt_o | output | 1 | Filtered SCL level |
| sda_filt_o | output | 1 | Filtered SDA level |
| mon_o | output | 4 | Monitor word: force SDA, force SCL, filtered SDA, filtered SCL |

## Verification
The clock generator is run with a symmetric split, an asymmetric fast-style split, and a setting where hold plus setup exceeds the low count. These separate the plain low count from the extended low phase and pin the change cycle at both ends. A stretched SCL shows whether the high count waits for the filtered line rather than for the release. Pulses one cycle shorter than the filter length and exactly at that length, on each line and with a zero length, show where the filter threshold lies. Single-bit force writes and a run request dropped in mid-phase check that the override bits are independent and that the low phase is not cut short.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam int unsigned MON_W       = 4;
  localparam int unsigned MON_SCL     = 0;
  localparam int unsigned MON_SDA     = 1;
  localparam int unsigned MON_FRC_SCL = 2;
  localparam int unsigned MON_FRC_SDA = 3;
  localparam int unsigned NUM_LINES   = 2;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC = 2,
  parameter int unsigned FW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] len_i,
  input  logic          raw_i,
  output logic          filt_o
);
  logic [SYNC-1:0] sync_q;
  logic [FW-1:0]   cnt_q;
  logic [FW:0]     cnt_inc, len_eff;
  logic            synced, filt_q;

  assign synced  = sync_q[SYNC-1];
  assign cnt_inc = {1'b0, cnt_q} + (FW+1)'(1);
  assign len_eff = (len_i == '0) ? (FW+1)'(1) : {1'b0, len_i};
  assign filt_o  = filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw_i};
      if (synced != filt_q) begin
        // commit only after len_eff consecutive differing samples
        if (cnt_inc >= len_eff) begin
          filt_q <= synced;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc[FW-1:0];
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_tim_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          scl_filt_i,
  input  logic [CW-1:0] high_cyc_i,
  input  logic [CW-1:0] low_cyc_i,
  input  logic [CW-1:0] setup_cyc_i,
  input  logic [CW-1:0] hold_cyc_i,
  output logic          scl_low_o,
  output logic          sda_change_o
);
  localparam int unsigned XW = CW + 2;

  scl_phase_e    phase_q;
  logic [XW-1:0] cnt_q, cnt_inc;
  logic [XW-1:0] hold_x, setup_x, low_x, min_low, low_len, high_len;

  assign hold_x   = XW'(hold_cyc_i);
  assign setup_x  = XW'(setup_cyc_i);
  assign low_x    = XW'(low_cyc_i);
  assign min_low  = hold_x + setup_x + XW'(1);
  assign low_len  = (low_x > min_low) ? low_x : min_low;
  assign high_len = (high_cyc_i == '0) ? XW'(1) : XW'(high_cyc_i);
  assign cnt_inc  = cnt_q + XW'(1);

  assign scl_low_o    = (phase_q == PH_LOW);
  assign sda_change_o = (phase_q == PH_LOW) && (cnt_q == hold_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (run_i) phase_q <= PH_LOW;
        end
        PH_LOW: begin
          if (cnt_inc >= low_len) begin
            phase_q <= PH_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_WAIT: begin
          // high count waits for the line itself: clock stretching
          cnt_q <= '0;
          if (scl_filt_i) phase_q <= PH_HIGH;
        end
        PH_HIGH: begin
          if (cnt_inc >= high_len) begin
            phase_q <= run_i ? PH_LOW : PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_override.sv
module i2c_bus_override (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_we_i,
  input  logic scl_val_i,
  input  logic sda_we_i,
  input  logic sda_val_i,
  output logic force_scl_o,
  output logic force_sda_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_scl_o <= 1'b0;
      force_sda_o <= 1'b0;
    end else begin
      if (scl_we_i) force_scl_o <= scl_val_i;
      if (sda_we_i) force_sda_o <= sda_val_i;
    end
  end
endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
  import i2c_tim_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned FW   = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CW-1:0]    scl_high_cyc_i,
  input  logic [CW-1:0]    scl_low_cyc_i,
  input  logic [CW-1:0]    sda_setup_cyc_i,
  input  logic [CW-1:0]    sda_hold_cyc_i,
  input  logic [FW-1:0]    filt_len_i,
  input  logic             scl_raw_i,
  input  logic             sda_raw_i,
  input  logic             ovr_scl_we_i,
  input  logic             ovr_scl_i,
  input  logic             ovr_sda_we_i,
  input  logic             ovr_sda_i,
  output logic             scl_drive_low_o,
  output logic             sda_force_low_o,
  output logic             sda_change_o,
  output logic             scl_filt_o,
  output logic             sda_filt_o,
  output logic [MON_W-1:0] mon_o
);
  logic [NUM_LINES-1:0] raw_lines, filt_lines;
  logic                 gen_low, frc_scl, frc_sda;

  assign raw_lines[MON_SCL] = scl_raw_i;
  assign raw_lines[MON_SDA] = sda_raw_i;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    i2c_line_filter #(.SYNC(SYNC), .FW(FW)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .len_i  (filt_len_i),
      .raw_i  (raw_lines[i]),
      .filt_o (filt_lines[i])
    );
  end

  i2c_scl_gen #(.CW(CW)) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .scl_filt_i   (filt_lines[MON_SCL]),
    .high_cyc_i   (scl_high_cyc_i),
    .low_cyc_i    (scl_low_cyc_i),
    .setup_cyc_i  (sda_setup_cyc_i),
    .hold_cyc_i   (sda_hold_cyc_i),
    .scl_low_o    (gen_low),
    .sda_change_o (sda_change_o)
  );

  i2c_bus_override u_ovr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_we_i    (ovr_scl_we_i),
    .scl_val_i   (ovr_scl_i),
    .sda_we_i    (ovr_sda_we_i),
    .sda_val_i   (ovr_sda_i),
    .force_scl_o (frc_scl),
    .force_sda_o (frc_sda)
  );

  assign scl_drive_low_o = gen_low | frc_scl;
  assign sda_force_low_o = frc_sda;
  assign scl_filt_o      = filt_lines[MON_SCL];
  assign sda_filt_o      = filt_lines[MON_SDA];

  always_comb begin
    mon_o              = '0;
    mon_o[MON_SCL]     = filt_lines[MON_SCL];
    mon_o[MON_SDA]     = filt_lines[MON_SDA];
    mon_o[MON_FRC_SCL] = frc_scl;
    mon_o[MON_FRC_SDA] = frc_sda;
  end
endmodule

// File: rtl/i2c_scl_timing_chk.sv
module i2c_scl_timing_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_drive_low_o,
  input logic          sda_change_o,
  input logic [3:0]    mon_o,
  input logic          ovr_scl_we_i,
  input logic          ovr_sda_we_i,
  input logic [CW-1:0] scl_low_cyc_i,
  input logic [CW-1:0] sda_setup_cyc_i
);
  localparam int unsigned KW = CW + 2;

  logic [KW-1:0] low_run_q, since_chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q   <= '0;
      since_chg_q <= '0;
    end else begin
      if (!scl_drive_low_o) low_run_q <= '0;
      else if (low_run_q != '1) low_run_q <= low_run_q + KW'(1);
      if (sda_change_o) since_chg_q <= KW'(1);
      else if (since_chg_q != '1) since_chg_q <= since_chg_q + KW'(1);
    end
  end

  assert_low_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_drive_low_o) && !$past(mon_o[2])) |-> (low_run_q >= KW'(scl_low_cyc_i)));

  assert_single_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_o |=> !sda_change_o);

  assert_setup_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_drive_low_o) && !$past(mon_o[2])) |-> (since_chg_q > KW'(sda_setup_cyc_i)));

  assert_force_scl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_o[2] |-> scl_drive_low_o);

  assert_sda_bit_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_scl_we_i && !ovr_sda_we_i) |=> $stable(mon_o[3]));

  assert_scl_bit_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_sda_we_i && !ovr_scl_we_i) |=> $stable(mon_o[2]));
endmodule

bind i2c_scl_timing i2c_scl_timing_chk #(.CW(CW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .scl_drive_low_o (scl_drive_low_o),
  .sda_change_o    (sda_change_o),
  .mon_o           (mon_o),
  .ovr_scl_we_i    (ovr_scl_we_i),
  .ovr_sda_we_i    (ovr_sda_we_i),
  .scl_low_cyc_i   (scl_low_cyc_i),
  .sda_setup_cyc_i (sda_setup_cyc_i)
);

// File: tb/i2c_scl_timing_bench.sv
module i2c_scl_timing_bench;
  localparam int CW = 16;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, stretch = 1'b0, sda_drv = 1'b1;
  logic [CW-1:0] hi_c = 10, lo_c = 10, su_c = 2, hd_c = 3;
  logic [FW-1:0] fl_c = 2;
  logic oscl_we = 0, oscl = 0, osda_we = 0, osda = 0;
  logic drv, sfrc, chg, sfilt, dfilt;
  logic [3:0] mon;
  wire scl_raw = ~drv & ~stretch;
  wire sda_raw = sda_drv & ~sfrc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_scl_timing u_i2c_scl_timing (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .scl_high_cyc_i(hi_c), .scl_low_cyc_i(lo_c),
    .sda_setup_cyc_i(su_c), .sda_hold_cyc_i(hd_c), .filt_len_i(fl_c),
    .scl_raw_i(scl_raw), .sda_raw_i(sda_raw),
    .ovr_scl_we_i(oscl_we), .ovr_scl_i(oscl), .ovr_sda_we_i(osda_we), .ovr_sda_i(osda),
    .scl_drive_low_o(drv), .sda_force_low_o(sfrc), .sda_change_o(chg),
    .scl_filt_o(sfilt), .sda_filt_o(dfilt), .mon_o(mon));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(string tag, int act, int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  // behavioural reference
  int m_ph, m_k, m_srun, m_drun;
  bit m_sf, m_df, m_fscl, m_fsda;
  bit q_s[$], q_d[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_srun = 0; m_drun = 0;
      m_sf = 1; m_df = 1; m_fscl = 0; m_fsda = 0;
      q_s = '{1'b1, 1'b1}; q_d = '{1'b1, 1'b1};
    end else begin
      int lowlen, hlen, fe;
      bit old_sf, s;
      lowlen = (int'(lo_c) > int'(hd_c) + int'(su_c) + 1) ? int'(lo_c) : int'(hd_c) + int'(su_c) + 1;
      hlen   = (hi_c == 0) ? 1 : int'(hi_c);
      fe     = (fl_c == 0) ? 1 : int'(fl_c);
      old_sf = m_sf;
      s = q_s[$]; void'(q_s.pop_back()); q_s.push_front(scl_raw);
      if (s != m_sf) begin m_srun++; if (m_srun >= fe) begin m_sf = s; m_srun = 0; end end
      else m_srun = 0;
      s = q_d[$]; void'(q_d.pop_back()); q_d.push_front(sda_raw);
      if (s != m_df) begin m_drun++; if (m_drun >= fe) begin m_df = s; m_drun = 0; end end
      else m_drun = 0;
      case (m_ph)
        0: begin m_k = 0; if (run) m_ph = 1; end
        1: if (m_k + 1 >= lowlen) begin m_ph = 2; m_k = 0; end else m_k++;
        2: begin m_k = 0; if (old_sf) m_ph = 3; end
        default: if (m_k + 1 >= hlen) begin m_ph = run ? 1 : 0; m_k = 0; end else m_k++;
      endcase
      if (oscl_we) m_fscl = oscl;
      if (osda_we) m_fsda = osda;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 scl drive vs model", int'(drv), int'((m_ph == 1) | m_fscl));
      chk("R3 change strobe vs model", int'(chg), int'(m_ph == 1 && m_k == int'(hd_c)));
      chk("R7 filtered scl vs model", int'(sfilt), int'(m_sf));
      chk("R8 filtered sda vs model", int'(dfilt), int'(m_df));
      chk("R10 monitor word vs model", int'(mon), int'({m_fsda, m_fscl, m_df, m_sf}));
      chk("R11 sda force vs model", int'(sfrc), int'(m_fsda));
    end
  end

  task automatic meas_low(output int len, output int sidx);
    len = 0; sidx = -1;
    while (!drv) @(negedge clk);
    while (drv) begin
      if (chg) sidx = len;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic meas_gap(output int g);
    g = 0;
    while (!drv) begin g++; @(negedge clk); end
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic pulse_min(input bit on_sda, input int width, output int lo_seen);
    lo_seen = 1;
    @(negedge clk);
    if (on_sda) sda_drv = 0; else stretch = 1;
    for (int i = 0; i < width + 15; i++) begin
      if (i == width) begin sda_drv = 1; stretch = 0; end
      @(negedge clk);
      if ((on_sda ? mon[1] : mon[0]) == 1'b0) lo_seen = 0;
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin : stim
    int len, sidx, g;
    repeat (3) @(negedge clk);
    chk("R1 reset monitor", int'(mon), 3);
    chk("R1 reset scl drive", int'(drv), 0);
    chk("R1 reset strobe", int'(chg), 0);
    chk("R1 reset sda force", int'(sfrc), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // symmetric split
    run = 1;
    meas_low(len, sidx);
    chk("R2 low length", len, 10);
    chk("R3 change index", sidx, 3);
    chk_ge("R4 setup cycles", len - sidx - 1, 2);
    meas_gap(g);
    chk("R5 released length", g, 10 + 2 + 3);
    run = 0;
    meas_low(len, sidx);
    chk("R2 second low length", len, 10);
    settle();

    // setup dominates low count
    lo_c = 6; hd_c = 3; su_c = 5; hi_c = 4; fl_c = 1;
    run = 1;
    meas_low(len, sidx);
    run = 0;
    chk("R2 extended low length", len, 9);
    chk("R3 change index extended", sidx, 3);
    chk("R4 exact setup cycles", len - sidx - 1, 5);
    settle();

    // asymmetric split
    lo_c = 12; hi_c = 6; hd_c = 2; su_c = 2; fl_c = 2;
    run = 1;
    meas_low(len, sidx);
    chk("R2 fast low length", len, 12);
    meas_gap(g);
    run = 0;
    chk("R5 fast released length", g, 6 + 2 + 3);
    settle();

    // clock stretching
    lo_c = 10; hi_c = 10; hd_c = 3; su_c = 2;
    run = 1;
    while (!drv) @(negedge clk);
    stretch = 1;
    meas_low(len, sidx);
    g = 0;
    while (!drv) begin
      if (g == 20) stretch = 0;
      g++;
      @(negedge clk);
    end
    run = 0;
    chk_ge("R6 stretched released length", g, 20 + 10);
    settle();

    // filter thresholds
    fl_c = 4;
    repeat (5) @(negedge clk);
    pulse_min(1, 3, g); chk("R8 short sda pulse rejected", g, 1);
    pulse_min(1, 4, g); chk("R8 sda pulse at length passes", g, 0);
    pulse_min(0, 3, g); chk("R7 short scl pulse rejected", g, 1);
    pulse_min(0, 5, g); chk("R7 long scl pulse passes", g, 0);
    fl_c = 0;
    pulse_min(1, 1, g); chk("R7 zero length acts as one", g, 0);
    fl_c = 2;
    settle();

    // override bits
    osda_we = 1; osda = 1; @(negedge clk); osda_we = 0;
    chk("R11 sda force set", int'(sfrc), 1);
    oscl_we = 1; oscl = 1; @(negedge clk); oscl_we = 0;
    chk("R9 scl forced low", int'(drv), 1);
    chk("R10 monitor force bits", int'(mon[3:2]), 3);
    oscl_we = 1; oscl = 0; @(negedge clk); oscl_we = 0;
    chk("R10 sda bit kept on scl write", int'(mon[3]), 1);
    chk("R9 scl released after clear", int'(drv), 0);
    osda_we = 1; osda = 0; @(negedge clk); osda_we = 0;
    chk("R11 sda force cleared", int'(sfrc), 0);
    settle();

    // run dropped mid-low
    run = 1;
    while (!drv) @(negedge clk);
    len = 0;
    while (drv) begin
      if (len == 2) run = 0;
      len++;
      @(negedge clk);
    end
    chk("R12 low completes after run drop", len, 10);
    g = 0;
    for (int i = 0; i < 60; i++) begin
      if (drv) g++;
      @(negedge clk);
    end
    chk("R12 stays idle", g, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule